// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier with Power Sequencer

This block multiplies two 12-bit elements of the field GF(2^12). The field is built in two levels. The base level is GF(64), generated by x^6 + x + 1. The upper level is a quadratic extension over GF(64). Each 12-bit element is split into a high six-bit half (bits 11:6) and a low six-bit half (bits 5:0). A product takes four GF(64) multiplies: three with data operands and one with the fixed constant 0x21.

A multiply request is a pair of operands qualified by a valid strobe. The product is registered and appears one clock later. Both operands are external inputs, so a multiply can be issued on every cycle.

Beside the multiplier, the block holds a power sequencer that walks through the successive powers of a fixed generator (default 0xE01). Its outputs are the power and its exponent, which is the information needed to fill log and antilog tables.

The sequencer is a three-state machine:
- **SEQ_IDLE** is the state after reset. A step command here is ignored.
- A start command moves the machine from any state to **SEQ_ARMED**. Start wins over a step given in the same cycle.
- The first step in SEQ_ARMED emits the value 1 with exponent 0 and moves the machine to **SEQ_RUN**. The value 1 is defined as the successor of 0.
- Each step in SEQ_RUN multiplies the current power by the generator and advances the exponent modulo 4095.

Top module: `gf_tower_mul`

## Requirements
- R1: For a = {ah, al} and b = {bh, bl}, the product is {hi, lo}, with · meaning GF(64) multiplication modulo x^6+x+1:
  - hi = ((ah⊕al)·(bh⊕bl)) ⊕ (al·bl)
  - lo = (ah·bh·0x21) ⊕ (al·bl)
- R2: `prod_vld_o` is high exactly in the cycle after a cycle with `mul_vld_i` high. `prod_o` holds its last value whenever no multiply was accepted in the previous cycle.
- R3: A zero operand gives the product 0. An operand equal to 1 gives the other operand unchanged.
- R4: While reset is asserted and right after it is released:
  - `prod_o`, `pow_o` and `pow_idx_o` are 0.
  - All valid and wrap flags are low.
  - The sequencer is in SEQ_IDLE.
- R5: A start command produces no `pow_vld_o` in the following cycle and leaves `pow_o` unchanged. Start takes priority over a step given in the same cycle, which is then ignored.
- R6: The first step after a start yields `pow_o` = 1 and `pow_idx_o` = 0, with `pow_vld_o` high one cycle after the step.
- R7: Each later step yields the previous power times the generator, one cycle after the step. `pow_idx_o` advances by one, wrapping from 4094 to 0.
- R8: `pow_wrap_o` pulses together with `pow_vld_o` exactly when a step in SEQ_RUN returns the value 1. For the default generator this happens on the 4096th step after start, with `pow_idx_o` = 0, and stepping then continues with the generator itself at index 1.
- R9: A step while in SEQ_IDLE has no effect: `pow_vld_o` stays low and `pow_o` and `pow_idx_o` are unchanged.
- R10: In a cycle after one without a step, `pow_vld_o` and `pow_wrap_o` are low, and `pow_o` and `pow_idx_o` hold.
- R11: A multiply and a sequencer step issued in the same cycle are both served with their normal one-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mul_vld_i | input | 1 | Multiply request strobe |
| mul_a_i | input | 12 | First operand |
| mul_b_i | input | 12 | Second operand |
| prod_o | output | 12 | Registered product |
| prod_vld_o | output | 1 | Product valid, one cycle after the request |
| seq_start_i | input | 1 | Arm the power sequencer |
| seq_step_i | input | 1 | Advance the power sequencer |
| pow_o | output | 12 | Current generator power |
| pow_vld_o | output | 1 | New power emitted this cycle |
| pow_idx_o | output | 12 | Exponent of `pow_o`, modulo 4095 |
| pow_wrap_o | output | 1 | The sequence has returned to 1 |

## Verification
The bench builds the block with its default parameters: six-bit halves, base polynomial 0x43, extension constant 0x21 and generator 0xE01. With these values the full 4095-element cycle of powers fits in a short run.

The whole cycle is stepped through, and every power, exponent and wrap flag is compared against a bench-side shift-and-add model. This also confirms that the generator is primitive, because the wrap appears only on the 4096th step.

Multiplier checks cover:
- walking and spread operand patterns;
- the all-ones operands;
- zero and identity operands;
- hold behaviour between requests;
- a multiply issued in the same cycle as a sequencer step.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

    // Default construction of the field: six-bit halves over x^6+x+1
    localparam int          GF_HALF_W_DEF = 6;
    localparam logic [6:0]  GF_POLY_DEF   = 7'h43;
    localparam logic [5:0]  GF_BETA_DEF   = 6'h21;
    localparam logic [11:0] GF_GEN_DEF    = 12'hE01;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
    parameter int           HW   = 6,
    parameter logic [HW:0]  POLY = 7'h43
) (
    input  logic [HW-1:0] a_i,
    input  logic [HW-1:0] b_i,
    output logic [HW-1:0] p_o
);

    // shifted[i] = b * x^i reduced, partial[i] = running sum
    logic [HW-1:0] shifted [HW];
    logic [HW-1:0] partial [HW+1];

    assign shifted[0] = b_i;
    assign partial[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < HW; gi++) begin : g_xtime
            assign shifted[gi] = {shifted[gi-1][HW-2:0], 1'b0}
                               ^ (shifted[gi-1][HW-1] ? POLY[HW-1:0] : '0);
        end
        for (gi = 0; gi < HW; gi++) begin : g_acc
            assign partial[gi+1] = partial[gi] ^ (a_i[gi] ? shifted[gi] : '0);
        end
    endgenerate

    assign p_o = partial[HW];

endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul #(
    parameter int           HW   = 6,
    parameter logic [HW:0]  POLY = 7'h43,
    parameter logic [HW-1:0] BETA = 6'h21
) (
    input  logic [2*HW-1:0] a_i,
    input  logic [2*HW-1:0] b_i,
    output logic [2*HW-1:0] p_o
);

    localparam int W = 2 * HW;

    logic [HW-1:0] ah, al, bh, bl;
    logic [HW-1:0] sum_a, sum_b;
    logic [HW-1:0] m_sum, m_low, m_high, m_beta;

    assign ah    = a_i[W-1:HW];
    assign al    = a_i[HW-1:0];
    assign bh    = b_i[W-1:HW];
    assign bl    = b_i[HW-1:0];
    assign sum_a = ah ^ al;
    assign sum_b = bh ^ bl;

    gf64_mul #(.HW(HW), .POLY(POLY)) u_sum  (.a_i(sum_a),  .b_i(sum_b), .p_o(m_sum));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_low  (.a_i(al),     .b_i(bl),    .p_o(m_low));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_high (.a_i(ah),     .b_i(bh),    .p_o(m_high));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_beta (.a_i(m_high), .b_i(BETA),  .p_o(m_beta));

    assign p_o = {m_sum ^ m_low, m_beta ^ m_low};

endmodule

// File: rtl/gf_pow_seq.sv
module gf_pow_seq
    import gf_tower_pkg::*;
#(
    parameter int            HW   = 6,
    parameter logic [HW:0]   POLY = 7'h43,
    parameter logic [HW-1:0] BETA = 6'h21,
    parameter logic [2*HW-1:0] GEN = 12'hE01
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            step_i,
    output logic [2*HW-1:0] pow_o,
    output logic            pow_vld_o,
    output logic [2*HW-1:0] pow_idx_o,
    output logic            pow_wrap_o
);

    localparam int W     = 2 * HW;
    localparam int ORDER = (1 << W) - 1;

    seq_state_e state_q, state_d;

    logic [W-1:0] pow_q, idx_q, times_gen;
    logic         vld_q, wrap_q;

    gf4096_mul #(.HW(HW), .POLY(POLY), .BETA(BETA)) u_gen_mul (
        .a_i (pow_q),
        .b_i (GEN),
        .p_o (times_gen)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start_i) state_d = SEQ_ARMED;
            SEQ_ARMED: if (start_i) state_d = SEQ_ARMED;
                       else if (step_i) state_d = SEQ_RUN;
            SEQ_RUN:   if (start_i) state_d = SEQ_ARMED;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEQ_IDLE;
        else         state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pow_q  <= '0;
            idx_q  <= '0;
            vld_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            wrap_q <= 1'b0;
            if (!start_i && step_i) begin
                unique case (state_q)
                    SEQ_IDLE: ;
                    SEQ_ARMED: begin
                        pow_q <= W'(1);
                        idx_q <= '0;
                        vld_q <= 1'b1;
                    end
                    SEQ_RUN: begin
                        pow_q  <= times_gen;
                        idx_q  <= (idx_q == W'(ORDER - 1)) ? '0 : idx_q + W'(1);
                        vld_q  <= 1'b1;
                        wrap_q <= (times_gen == W'(1));
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pow_o      = pow_q;
    assign pow_idx_o  = idx_q;
    assign pow_vld_o  = vld_q;
    assign pow_wrap_o = wrap_q;

    // R5
    start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !pow_vld_o && state_q == SEQ_ARMED && pow_o == $past(pow_o));

    // R6
    first_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_ARMED && step_i && !start_i) |=> pow_vld_o && pow_o == W'(1) && pow_idx_o == '0);

    // R7
    run_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_RUN && step_i && !start_i) |=> pow_vld_o && pow_o != '0);

    // R8
    wrap_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pow_wrap_o |-> pow_vld_o && pow_o == W'(1));

    // R9
    idle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_IDLE) |=> !pow_vld_o && $stable(pow_o) && $stable(pow_idx_o));

    // R10
    no_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> !pow_vld_o && !pow_wrap_o && $stable(pow_o) && $stable(pow_idx_o));

endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul
    import gf_tower_pkg::*;
#(
    parameter int            HALF_W = GF_HALF_W_DEF,
    parameter logic [HALF_W:0]   POLY = GF_POLY_DEF,
    parameter logic [HALF_W-1:0] BETA = GF_BETA_DEF,
    parameter logic [2*HALF_W-1:0] GEN = GF_GEN_DEF
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  mul_vld_i,
    input  logic [2*HALF_W-1:0]   mul_a_i,
    input  logic [2*HALF_W-1:0]   mul_b_i,
    output logic [2*HALF_W-1:0]   prod_o,
    output logic                  prod_vld_o,
    input  logic                  seq_start_i,
    input  logic                  seq_step_i,
    output logic [2*HALF_W-1:0]   pow_o,
    output logic                  pow_vld_o,
    output logic [2*HALF_W-1:0]   pow_idx_o,
    output logic                  pow_wrap_o
);

    localparam int W = 2 * HALF_W;

    logic [W-1:0] prod_comb, prod_q;
    logic         prod_vld_q;

    gf4096_mul #(.HW(HALF_W), .POLY(POLY), .BETA(BETA)) u_mul (
        .a_i (mul_a_i),
        .b_i (mul_b_i),
        .p_o (prod_comb)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prod_q     <= '0;
            prod_vld_q <= 1'b0;
        end else begin
            prod_vld_q <= mul_vld_i;
            if (mul_vld_i) prod_q <= prod_comb;
        end
    end

    assign prod_o     = prod_q;
    assign prod_vld_o = prod_vld_q;

    gf_pow_seq #(.HW(HALF_W), .POLY(POLY), .BETA(BETA), .GEN(GEN)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (seq_start_i),
        .step_i     (seq_step_i),
        .pow_o      (pow_o),
        .pow_vld_o  (pow_vld_o),
        .pow_idx_o  (pow_idx_o),
        .pow_wrap_o (pow_wrap_o)
    );

    // R2
    prod_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mul_vld_i |=> prod_vld_o);

    // R2
    prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mul_vld_i |=> !prod_vld_o && $stable(prod_o));

    // R3
    zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mul_vld_i && (mul_a_i == '0 || mul_b_i == '0)) |=> prod_o == '0);

    // R3
    unit_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mul_vld_i && mul_a_i == W'(1)) |=> prod_o == $past(mul_b_i));

endmodule

// File: tb/gf_tower_mul_tb_top.sv
module gf_tower_mul_tb_top;

    localparam logic [11:0] GEN = 12'hE01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mul_vld = 1'b0;
    logic [11:0] mul_a = '0, mul_b = '0;
    logic        seq_start = 1'b0, seq_step = 1'b0;
    logic [11:0] prod, pow_v, pow_idx;
    logic        prod_vld, pow_vld, pow_wrap;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    gf_tower_mul dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .mul_vld_i(mul_vld), .mul_a_i(mul_a), .mul_b_i(mul_b),
        .prod_o(prod), .prod_vld_o(prod_vld),
        .seq_start_i(seq_start), .seq_step_i(seq_step),
        .pow_o(pow_v), .pow_vld_o(pow_vld), .pow_idx_o(pow_idx), .pow_wrap_o(pow_wrap)
    );

    function automatic logic [5:0] m64(input logic [5:0] a, input logic [5:0] b);
        logic [6:0] bb;
        logic [5:0] c;
        c  = '0;
        bb = {1'b0, b};
        for (int i = 0; i < 6; i++) begin
            if (a[i]) c ^= bb[5:0];
            bb = bb << 1;
            if (bb[6]) bb ^= 7'h43;
        end
        return c;
    endfunction

    function automatic logic [11:0] m4096(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hi, lo;
        hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
        lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mul_once(input logic [11:0] a, input logic [11:0] b, input string req);
        logic [11:0] e;
        e = m4096(a, b);
        @(negedge clk);
        mul_vld = 1'b1; mul_a = a; mul_b = b;
        @(negedge clk);
        mul_vld = 1'b0;
        chk(prod_vld && prod == e, req, "product", int'({prod_vld, prod}), int'({1'b1, e}));
    endtask

    task automatic t_reset();
        chk(prod == 0 && !prod_vld, "R4", "prod in reset", int'({prod_vld, prod}), 0);
        chk(pow_v == 0 && pow_idx == 0 && !pow_vld && !pow_wrap, "R4", "pow in reset",
            int'({pow_wrap, pow_vld, pow_idx, pow_v}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(prod == 0 && !prod_vld && pow_v == 0 && !pow_vld, "R4", "after release",
            int'({prod_vld, pow_vld, pow_v}), 0);
    endtask

    task automatic t_idle_step();
        @(negedge clk); seq_step = 1'b1;
        @(negedge clk); @(negedge clk); seq_step = 1'b0;
        chk(!pow_vld && pow_v == 0 && pow_idx == 0, "R9", "step in idle",
            int'({pow_vld, pow_idx, pow_v}), 0);
    endtask

    task automatic t_mul_patterns();
        for (int i = 0; i < 12; i++) mul_once(12'(1 << i), 12'(12'h800 >> (i % 7)), "R1");
        for (int i = 0; i < 24; i++) mul_once(12'(i * 1237 + 91), 12'(i * 2749 + 333), "R1");
        mul_once(12'hFFF, 12'hFFF, "R1");
        mul_once(12'h040, 12'h040, "R1");
    endtask

    task automatic t_mul_hold();
        logic [11:0] e;
        e = m4096(12'hA5C, 12'h3E7);
        @(negedge clk); mul_vld = 1'b1; mul_a = 12'hA5C; mul_b = 12'h3E7;
        @(negedge clk); mul_vld = 1'b0; mul_a = 12'h111; mul_b = 12'h222;
        chk(prod_vld && prod == e, "R2", "one-cycle product", int'(prod), int'(e));
        @(negedge clk);
        chk(!prod_vld, "R2", "valid drops", int'(prod_vld), 0);
        chk(prod == e, "R2", "product holds", int'(prod), int'(e));
    endtask

    task automatic t_identity();
        @(negedge clk); mul_vld = 1'b1; mul_a = 12'h000; mul_b = 12'h9B3;
        @(negedge clk); mul_vld = 1'b0;
        chk(prod == 0, "R3", "zero times x", int'(prod), 0);
        @(negedge clk); mul_vld = 1'b1; mul_a = 12'h001; mul_b = 12'h6D2;
        @(negedge clk); mul_vld = 1'b0;
        chk(prod == 12'h6D2, "R3", "one times x", int'(prod), 12'h6D2);
        @(negedge clk); mul_vld = 1'b1; mul_a = 12'hC47; mul_b = 12'h001;
        @(negedge clk); mul_vld = 1'b0;
        chk(prod == 12'hC47, "R3", "x times one", int'(prod), 12'hC47);
    endtask

    task automatic t_sequence();
        logic [11:0] e;
        int          wraps, wrap_at;
        e = '0; wraps = 0; wrap_at = -1;
        @(negedge clk); seq_start = 1'b1;
        @(negedge clk); seq_start = 1'b0;
        chk(!pow_vld && pow_v == 0, "R5", "start emits nothing", int'({pow_vld, pow_v}), 0);
        seq_step = 1'b1;
        for (int s = 0; s <= 4096; s++) begin
            bit ew;
            ew = (s != 0) && (m4096(e, GEN) == 12'd1);
            e  = (s == 0) ? 12'd1 : m4096(e, GEN);
            @(negedge clk);
            if (s == 4096) seq_step = 1'b0;
            chk(pow_vld && pow_v == e && pow_idx == 12'(s % 4095) && pow_wrap == ew,
                (s == 0) ? "R6" : "R7", "power step",
                int'({pow_wrap, pow_vld, pow_idx, pow_v}),
                int'({ew, 1'b1, 12'(s % 4095), e}));
            if (pow_wrap) begin wraps++; wrap_at = s; end
        end
        chk(wraps == 1 && wrap_at == 4095, "R8", "single wrap at step 4096", wrap_at, 4095);
        @(negedge clk);
        chk(!pow_vld && !pow_wrap && pow_v == GEN && pow_idx == 1, "R10", "hold without step",
            int'({pow_vld, pow_idx, pow_v}), int'({1'b0, 12'd1, GEN}));
    endtask

    task automatic t_start_priority();
        logic [11:0] held;
        @(negedge clk); seq_step = 1'b1;
        @(negedge clk); seq_step = 1'b0;
        held = pow_v;
        @(negedge clk); seq_start = 1'b1; seq_step = 1'b1;
        @(negedge clk); seq_start = 1'b0;
        chk(!pow_vld && pow_v == held, "R5", "start beats step", int'({pow_vld, pow_v}), int'(held));
        @(negedge clk); seq_step = 1'b0;
        chk(pow_vld && pow_v == 1 && pow_idx == 0, "R6", "restart gives one",
            int'({pow_vld, pow_idx, pow_v}), int'({1'b1, 12'd0, 12'd1}));
    endtask

    task automatic t_concurrent();
        logic [11:0] e;
        e = m4096(12'h5AB, 12'hD0E);
        @(negedge clk); seq_step = 1'b1; mul_vld = 1'b1; mul_a = 12'h5AB; mul_b = 12'hD0E;
        @(negedge clk); seq_step = 1'b0; mul_vld = 1'b0;
        chk(prod_vld && prod == e, "R11", "product with step", int'(prod), int'(e));
        chk(pow_vld && pow_v == GEN && pow_idx == 1, "R11", "step with product",
            int'({pow_idx, pow_v}), int'({12'd1, GEN}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle_step();
        t_mul_patterns();
        t_mul_hold();
        t_identity();
        t_sequence();
        t_start_priority();
        t_concurrent();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule